// File: doc/BRIEF.md
# Slowdown-Instruction Pipeline Power Controller

This block sets the power modes of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) while supply voltage and clock frequency stay fixed. Software saves power by placing a reserved no-work slowdown instruction in the instruction stream. The controller recognises that instruction at fetch and follows it down the pipeline with a one-bit tag per stage. Each stage gets its own mix of clock gating, power gating and drowsy enables, and these are raised exactly while the slowdown sits in that stage. Storage that must keep its contents (program counter, register file, pipeline registers) is only clock-gated. The caches go drowsy. Combinational logic (ALU, FPU, comparators, branch decoding, forwarding and hazard logic, spare adders and multiplexers) is power-gated. The main control unit is never gated, so the block has no output for it.

A power-gated unit needs `WAKE_CYC` cycles, counted from its last gated cycle, before a real instruction may use it. Each stage runs a small wake-up state machine that reports when its units are usable again. When a real instruction reaches fetch before the fetch units are awake, the controller stalls fetch. While stalled, the environment holds the same fetch word and a bubble enters decode. Every downstream stage is separated from the slowdown by the same distance as fetch, so only fetch ever needs to stall.

Per-stage wake-up state machine:
- States: `ST_ON` (units usable unless gated this cycle) and `ST_WAKE` (waking, count pending).
- `ST_ON`/`ST_WAKE` -> `ST_WAKE` when the stage is gated and `WAKE_CYC > 1`, loading `WAKE_CYC-1`.
- `ST_ON` -> `ST_ON` when the stage is gated and `WAKE_CYC == 1`, or when it is idle.
- `ST_WAKE` -> `ST_ON` when the remaining count is 1 and the stage is not gated.
- Otherwise `ST_WAKE` counts down.

Top module: `sd_power_ctrl`

## Requirements
- R1: While `rst_n` is low, every gating, drowsy and tag output is 0, every `unit_awake` bit is 1 and `fetch_stall` is 0, whatever is presented at fetch.
- R2: A fetch word is a slowdown exactly when `if_valid` is 1 and its opcode field `if_instr[6:0]` is all ones (7'h7F). `sd_tag[0]` follows this in the same cycle. An invalid word, or any other opcode such as 7'h7E, is not a slowdown.
- R3: Each stage tag is the previous stage's tag delayed by one clock, in the order fetch(0), decode(1), execute(2), memory(3), writeback(4). A slowdown therefore occupies exactly one slot in each stage and leaves after writeback.
- R4: `pc_cg`, `icache_drowsy` and `if_pg` equal `sd_tag[0]`.
- R5: `regfile_cg` and `id_pg` equal `sd_tag[1]`; `ex_pg` equals `sd_tag[2]`; `dcache_drowsy` and `mem_pg` equal `sd_tag[3]`; `wb_pg` equals `sd_tag[4]`.
- R6: `preg_cg[k]` (the register at the output of stage k, k = 0..3) equals `sd_tag[k]`.
- R7: `unit_awake[k]` is 0 while `sd_tag[k]` is 1 and for the `WAKE_CYC-1` cycles after it was last 1; otherwise it is 1.
- R8: `fetch_stall` is 1 exactly when a valid non-slowdown word is at fetch and `unit_awake[0]` is 0. A slowdown or an invalid slot never stalls.
- R9: A real instruction that directly follows a slowdown in program order is accepted at fetch exactly `WAKE_CYC` cycles after the slowdown was, so with `WAKE_CYC = 1` one slowdown costs one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Fetch slot holds an instruction |
| if_instr | input | INSTR_W | Instruction word at fetch |
| fetch_stall | output | 1 | Hold fetch; a bubble enters decode |
| sd_tag | output | 5 | Slowdown present, per stage (bit 0 = fetch) |
| pc_cg | output | 1 | Clock gate for the program counter |
| icache_drowsy | output | 1 | Instruction cache drowsy enable |
| if_pg | output | 1 | Power gate for fetch combinational logic |
| regfile_cg | output | 1 | Clock gate for the register file |
| id_pg | output | 1 | Power gate for decode, branch, forwarding and hazard logic |
| ex_pg | output | 1 | Power gate for ALU, FPU, comparators and muxes |
| dcache_drowsy | output | 1 | Data cache drowsy enable |
| mem_pg | output | 1 | Power gate for memory-stage logic |
| wb_pg | output | 1 | Power gate for writeback logic |
| preg_cg | output | 4 | Clock gates for the stage output registers |
| unit_awake | output | 5 | Per-stage units usable by a real instruction |

## Verification
A tag that is lost, doubled or shifted by a wrong amount shows up on the enables of the stage it reaches, and it does so within one cycle of the error, because every enable is a direct decode of that stage's tag. A wake-up counter that is off by one shows up as `unit_awake` rising a cycle early or late. At fetch the same error appears as a stall that is one cycle too short or too long, and that moves the acceptance time of every later instruction. The bench keeps its own history of decoded fetch slots and derives every tag, enable, awake bit and stall from it. It compares all of them on every clock, including during reset, so any departure is reported in the cycle it first appears.

// File: rtl/sd_pwr_pkg.sv
package sd_pwr_pkg;

    localparam int NUM_STAGES = 5;
    localparam int NUM_PREGS  = NUM_STAGES - 1;

    // Stage indices; the tag vector and the awake vector use this order.
    localparam int STG_IF  = 0;
    localparam int STG_ID  = 1;
    localparam int STG_EX  = 2;
    localparam int STG_MEM = 3;
    localparam int STG_WB  = 4;

    // Wake-up state of the units of one stage.
    typedef enum logic {
        ST_ON   = 1'b0,
        ST_WAKE = 1'b1
    } wake_state_e;

endpackage

// File: rtl/sd_decode.sv
module sd_decode #(
    parameter int INSTR_W = 32,
    parameter int OPC_W   = 7,
    parameter int OPC_LSB = 0
) (
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               is_sd_o,
    output logic               is_real_o
);

    localparam logic [OPC_W-1:0] SD_OPCODE = '1;

    logic [OPC_W-1:0] opc;
    logic             opc_hit;

    always_comb begin
        opc       = instr_i[OPC_LSB +: OPC_W];
        opc_hit   = (opc == SD_OPCODE);
        is_sd_o   = rst_n && valid_i && opc_hit;
        is_real_o = rst_n && valid_i && !opc_hit;
    end

endmodule

// File: rtl/sd_tag_pipe.sv
module sd_tag_pipe #(
    parameter int NS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_i,
    output logic [NS-1:0] tag_o
);

    always_comb tag_o[0] = head_i;

    for (genvar k = 1; k < NS; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tag_o[k] <= 1'b0;
            else        tag_o[k] <= tag_o[k-1];
        end

        AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
            tag_o[k] == $past(tag_o[k-1])); // R3
    end

endmodule

// File: rtl/sd_stage_fsm.sv
module sd_stage_fsm
    import sd_pwr_pkg::*;
#(
    parameter int WAKE_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic awake_o
);

    localparam int CW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(WAKE_CYC - 1);

    wake_state_e   st_q, st_d;
    logic [CW-1:0] rem_q, rem_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_ON;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        if (gate_i) begin
            rem_d = RELOAD;
            st_d  = (WAKE_CYC > 1) ? ST_WAKE : ST_ON;
        end else begin
            unique case (st_q)
                ST_ON: begin
                    rem_d = '0;
                end
                ST_WAKE: begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q <= 1) st_d = ST_ON;
                end
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            ST_ON:   awake_o = !gate_i;
            ST_WAKE: awake_o = 1'b0;
        endcase
    end

    AST_GATED_NOT_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        gate_i |-> !awake_o); // R7

    AST_WAKE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate_i) && !gate_i) |-> (awake_o == (WAKE_CYC == 1))); // R7

endmodule

// File: rtl/sd_power_ctrl.sv
module sd_power_ctrl
    import sd_pwr_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int OPC_W    = 7,
    parameter int OPC_LSB  = 0,
    parameter int WAKE_CYC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               if_valid,
    input  logic [INSTR_W-1:0] if_instr,
    output logic               fetch_stall,
    output logic [4:0]         sd_tag,
    output logic               pc_cg,
    output logic               icache_drowsy,
    output logic               if_pg,
    output logic               regfile_cg,
    output logic               id_pg,
    output logic               ex_pg,
    output logic               dcache_drowsy,
    output logic               mem_pg,
    output logic               wb_pg,
    output logic [3:0]         preg_cg,
    output logic [4:0]         unit_awake
);

    logic                  head_sd;
    logic                  head_real;
    logic [NUM_STAGES-1:0] tag;
    logic [NUM_STAGES-1:0] awake;

    sd_decode #(
        .INSTR_W (INSTR_W),
        .OPC_W   (OPC_W),
        .OPC_LSB (OPC_LSB)
    ) u_decode (
        .rst_n     (rst_n),
        .valid_i   (if_valid),
        .instr_i   (if_instr),
        .is_sd_o   (head_sd),
        .is_real_o (head_real)
    );

    sd_tag_pipe #(
        .NS (NUM_STAGES)
    ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .head_i (head_sd),
        .tag_o  (tag)
    );

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_wake
        sd_stage_fsm #(
            .WAKE_CYC (WAKE_CYC)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate_i  (tag[k]),
            .awake_o (awake[k])
        );
    end

    // Per-unit mode outputs.
    always_comb begin
        sd_tag        = tag;
        unit_awake    = awake;
        pc_cg         = tag[STG_IF];
        icache_drowsy = tag[STG_IF];
        if_pg         = tag[STG_IF];
        regfile_cg    = tag[STG_ID];
        id_pg         = tag[STG_ID];
        ex_pg         = tag[STG_EX];
        dcache_drowsy = tag[STG_MEM];
        mem_pg        = tag[STG_MEM];
        wb_pg         = tag[STG_WB];
        preg_cg       = tag[NUM_PREGS-1:0];
        fetch_stall   = head_real && !awake[STG_IF];
    end

    AST_STALL_ONLY_REAL: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> (if_valid && !sd_tag[STG_IF])); // R8

    for (genvar k = 1; k < NUM_STAGES; k++) begin : g_awake_chk
        AST_AWAKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            unit_awake[k] == $past(unit_awake[k-1])); // R7
    end

    AST_GATES_LEAVE_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wb_pg) |-> (wb_pg == $past(mem_pg))); // R3

endmodule

// File: tb/sd_power_ctrl_tb.sv
module sd_power_ctrl_tb;

    localparam int WAKE_P = 3;
    localparam int NSTG   = 5;

    typedef struct {
        bit          v;
        logic [31:0] w;
    } slot_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_valid = 1'b0;
    logic [31:0] if_instr = '0;
    logic        fetch_stall;
    logic [4:0]  sd_tag;
    logic        pc_cg, icache_drowsy, if_pg, regfile_cg, id_pg, ex_pg;
    logic        dcache_drowsy, mem_pg, wb_pg;
    logic [3:0]  preg_cg;
    logic [4:0]  unit_awake;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    slot_t prog[$];
    bit    hist[$];

    always #2 clk = ~clk;

    sd_power_ctrl #(.WAKE_CYC(WAKE_P)) u_dut (
        .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_instr(if_instr),
        .fetch_stall(fetch_stall), .sd_tag(sd_tag), .pc_cg(pc_cg),
        .icache_drowsy(icache_drowsy), .if_pg(if_pg), .regfile_cg(regfile_cg),
        .id_pg(id_pg), .ex_pg(ex_pg), .dcache_drowsy(dcache_drowsy),
        .mem_pg(mem_pg), .wb_pg(wb_pg), .preg_cg(preg_cg), .unit_awake(unit_awake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic add(input bit v, input logic [6:0] opc);
        slot_t s;
        s.v = v;
        s.w = {25'($urandom), opc};
        prog.push_back(s);
    endtask

    // Fetch-stage tag i cycles ago (i = 0 is the current cycle).
    function automatic bit tag_ago(input int i, input bit cur);
        if (i == 0) return cur;
        if (i - 1 < hist.size()) return hist[i-1];
        return 1'b0;
    endfunction

    task automatic compare_all(input bit cur_sd, input bit cur_v, output bit exp_stall);
        logic [4:0] et, ea;
        for (int k = 0; k < NSTG; k++) begin
            et[k] = tag_ago(k, cur_sd);
            ea[k] = 1'b1;
            for (int j = 0; j < WAKE_P; j++)
                if (tag_ago(k + j, cur_sd)) ea[k] = 1'b0;
        end
        exp_stall = rst_n && cur_v && !cur_sd && !ea[0];
        chk("R2 fetch tag", 32'(sd_tag[0]), 32'(et[0]));
        chk("R3 stage tags", 32'(sd_tag), 32'(et));
        chk("R4 fetch gates", {29'd0, pc_cg, icache_drowsy, if_pg}, {29'd0, {3{et[0]}}});
        chk("R5 stage gates", {26'd0, regfile_cg, id_pg, ex_pg, dcache_drowsy, mem_pg, wb_pg},
            {26'd0, et[1], et[1], et[2], et[3], et[3], et[4]});
        chk("R6 pipe reg gates", 32'(preg_cg), 32'(et[3:0]));
        chk("R7 awake", 32'(unit_awake), 32'(ea));
        chk("R8 stall", 32'(fetch_stall), 32'(exp_stall));
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit st;
        bit prev_sd;
        int sd_cyc;
        // Program: R2/R9 corner cases.
        add(1, 7'h03); add(1, 7'h33); add(1, 7'h23);        // plain real sequence
        add(1, 7'h7F); add(1, 7'h33);                       // slowdown then real: stall
        add(1, 7'h7E);                                      // near-miss opcode
        add(1, 7'h7F); add(1, 7'h7F); add(1, 7'h7F); add(1, 7'h13); // back-to-back
        add(1, 7'h7F); add(0, 7'h00); add(0, 7'h00); add(1, 7'h13); // waited out, no stall
        add(1, 7'h7F); add(0, 7'h7F); add(1, 7'h63);        // invalid all-ones, one stall
        add(1, 7'h7F); add(1, 7'h7F); add(0, 7'h00); add(1, 7'h33);
        for (int i = 0; i < 8; i++) add(0, 7'h00);          // drain

        // R1: reset with a slowdown presented at fetch.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if_valid = 1'b1;
            if_instr = 32'h0000_007F;
            #1;
            chk("R1 reset tags", 32'(sd_tag), 32'd0);
            chk("R1 reset gates", {22'd0, pc_cg, icache_drowsy, if_pg, regfile_cg, id_pg,
                ex_pg, dcache_drowsy, mem_pg, wb_pg, |preg_cg}, 32'd0);
            chk("R1 reset awake", 32'(unit_awake), 32'h1F);
            chk("R1 reset stall", 32'(fetch_stall), 32'd0);
            @(posedge clk);
            hist.push_front(1'b0);
            cyc++;
        end

        prev_sd = 1'b0;
        sd_cyc = 0;
        for (int pc = 0; pc < prog.size(); ) begin
            bit cur_sd;
            @(negedge clk);
            rst_n = 1'b1;
            if_valid = prog[pc].v;
            if_instr = prog[pc].w;
            #1;
            cur_sd = prog[pc].v && (prog[pc].w[6:0] == 7'h7F);
            compare_all(cur_sd, prog[pc].v, st);
            @(posedge clk);
            hist.push_front(cur_sd);
            if (!st) begin
                if (prev_sd && prog[pc].v && !cur_sd)
                    chk("R9 issue distance", 32'(cyc - sd_cyc), 32'(WAKE_P));
                if (cur_sd) sd_cyc = cyc;
                prev_sd = cur_sd;
                pc++;
            end
            cyc++;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule